// File: doc/BRIEF.md
# Watchdog Timer with Interrupt Option

This block supervises software running on a small microcontroller. Once enabled, it counts pulses of a slow timebase tick (nominally 128 Hz). If software does not restart it before the selected period runs out, the timer expires. On expiry it either requests a system reset or raises an interrupt. One 8-bit control register, reached through a plain write/read port, holds all of its settings.

The register is guarded against stray writes. A write that sets the unlock bit opens a window that lasts exactly one clock cycle. Only a write made in that window changes the settings. Every such accepted write also restarts the count.

The timeout select takes one of eight periods. Each period is twice the one before it. A ninth code asks for a reset at once. The remaining codes are refused and leave the timeout select as it was. The interrupt vector address is a fixed output for the interrupt controller.

Register layout, MSB first: [7] unlock, [6] run enable, [5] expiry status, [4] interrupt mode (1 = interrupt, 0 = reset), [3:0] timeout code.

Top module: `wdog_timer`

## Requirements
- R1: After reset the register reads 0x00, and rst_req_o and irq_o are low.
- R2: A write with bit 7 set, made while no window is open, opens a one-cycle unlock window. Bit 7 reads 1 only during that cycle.
- R3: A write is accepted only in the cycle right after the unlock write. Any other write leaves the register unchanged.
- R4: When enabled with timeout code n (0 to 7), expiry occurs on tick number BASE_TICKS<<n (default 2<<n, roughly 15.6 ms up to 2 s at 128 Hz).
- R5: In reset mode, expiry gives a one-cycle rst_req_o pulse in the cycle after the expiring tick. It also sets status, and counting starts again from zero.
- R6: In interrupt mode, expiry sets status and never pulses rst_req_o. irq_o is high whenever status and interrupt mode are both set.
- R7: Status is cleared only by an accepted write with bit 5 at 0. A write that is not accepted leaves it set.
- R8: An accepted write with code 1000 pulses rst_req_o for one cycle, in the cycle after acceptance. While that code is held, counting stops.
- R9: An accepted write with a code from 1001 to 1111 keeps the previous timeout code. The other fields still take the written values.
- R10: Every accepted write clears the count, so writing the enable bit again restarts the full period.
- R11: irq_vec_o always presents the interrupt vector 0x5B.
- R12: With the enable bit clear, ticks do not advance the count and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | Timebase tick, one cycle per pulse |
| rd_data_o | output | 8 | Register read value |
| rst_req_o | output | 1 | System reset request pulse |
| irq_o | output | 1 | Watchdog interrupt request |
| irq_vec_o | output | 8 | Interrupt vector address |

## Verification
The assertions assume the block leaves reset in a known state and that wr_en_i and tick_i are clean one-cycle-resolved levels. They assume nothing about the tick rate or about how writes and ticks are spaced. The stimulus drives every input at the falling edge, holds tick_i for whole cycles, and mixes unlocked, late and stray writes with tick bursts. This lets writes land in the same cycle as a tick, including the tick that would cause expiry, where the restart takes precedence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_CODES = 8;
  localparam int CODE_W    = 4;
  localparam logic [CODE_W-1:0] IMM_CODE = 4'h8;

  typedef struct packed {
    logic              arm;
    logic              en;
    logic              status;
    logic              mode;
    logic [CODE_W-1:0] code;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic      expire_i,
  output wdt_ctrl_t ctrl_o,
  output logic      accept_o,
  output logic      imm_o
);
  wdt_ctrl_t ctrl_q;
  logic      imm_q;
  logic      accept;

  assign accept = wr_en_i & ctrl_q.arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      imm_q  <= 1'b0;
    end else begin
      ctrl_q.arm    <= wr_en_i & ~ctrl_q.arm & wr_data_i[7];
      imm_q         <= accept & (wr_data_i[3:0] == IMM_CODE);
      ctrl_q.status <= expire_i | (ctrl_q.status & ~(accept & ~wr_data_i[5]));
      if (accept) begin
        ctrl_q.en   <= wr_data_i[6];
        ctrl_q.mode <= wr_data_i[4];
        // codes above the immediate-reset code are refused
        if (wr_data_i[3:0] <= IMM_CODE) ctrl_q.code <= wr_data_i[3:0];
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign accept_o = accept;
  assign imm_o    = imm_q;

  assert_arm_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.arm |=> !ctrl_q.arm);
  assert_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ctrl_q.en, ctrl_q.mode, ctrl_q.code}) |-> $past(ctrl_q.arm && wr_en_i));
  assert_status_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.status) |-> $past(ctrl_q.arm && wr_en_i));
  assert_code_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.code <= IMM_CODE);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       run_i,
  input  logic [$clog2(NUM_CODES)-1:0] code_i,
  input  logic                       tick_i,
  output logic                       expire_o
);
  localparam int SEL_W = $clog2(NUM_CODES);
  localparam int CW    = $clog2(BASE_TICKS << (NUM_CODES - 1));

  logic [CW-1:0] lim_tab [NUM_CODES];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          hit;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_lim
    assign lim_tab[i] = CW'((BASE_TICKS << i) - 1);
  end

  assign lim_m1   = lim_tab[code_i];
  assign hit      = run_i & tick_i & (cnt_q == lim_m1);
  assign expire_o = hit & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || hit)      cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_m1);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int         BASE_TICKS = 2,
  parameter logic [7:0] IRQ_VECTOR = 8'h5B
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       tick_i,
  output logic [7:0] rd_data_o,
  output logic       rst_req_o,
  output logic       irq_o,
  output logic [7:0] irq_vec_o
);
  wdt_ctrl_t ctrl;
  logic      accept, imm, expire, run, exp_rst_q;

  wdt_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .expire_i (expire),
    .ctrl_o   (ctrl),
    .accept_o (accept),
    .imm_o    (imm)
  );

  assign run = ctrl.en & (ctrl.code != IMM_CODE);

  wdt_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i    (accept),
    .run_i    (run),
    .code_i   (ctrl.code[$clog2(NUM_CODES)-1:0]),
    .tick_i,
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_rst_q <= 1'b0;
    else         exp_rst_q <= expire & ~ctrl.mode;
  end

  assign rst_req_o = imm | exp_rst_q;
  assign irq_o     = ctrl.status & ctrl.mode;
  assign rd_data_o = ctrl;
  assign irq_vec_o = IRQ_VECTOR;

  assert_rst_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(!ctrl.mode || accept));
  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  assert_expire_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> ctrl.status);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       tick_i = 1'b0;
  logic [7:0] rd_data_o, irq_vec_o;
  logic       rst_req_o, irq_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state (value after the latest rising edge)
  bit m_arm, m_en, m_st, m_mode, m_imm, m_xrst;
  int m_code, m_cnt;

  always #4 clk = ~clk;

  wdog_timer uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .tick_i,
    .rd_data_o, .rst_req_o, .irq_o, .irq_vec_o
  );

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    exp_rd = (int'(m_arm) << 7) | (int'(m_en) << 6) | (int'(m_st) << 5) |
             (int'(m_mode) << 4) | m_code;
    chk({tag, " rd"}, rd_data_o, exp_rd);
    chk({tag, " rst"}, rst_req_o, m_imm | m_xrst);
    chk({tag, " irq"}, irq_o, m_st & m_mode);
  endtask

  task automatic model(input bit we, input bit [7:0] wd, input bit tk);
    bit acc, exp, run;
    int lim;
    acc = we && m_arm;
    run = m_en && (m_code < 8);
    lim = 2 * (1 << (m_code % 8));
    exp = !acc && run && tk && (m_cnt == lim - 1);
    if (acc) m_cnt = 0;
    else if (run && tk) m_cnt = exp ? 0 : m_cnt + 1;
    m_xrst = exp && !m_mode;
    m_imm  = acc && (wd[3:0] == 4'h8);
    m_st   = exp || (m_st && !(acc && !wd[5]));
    if (acc) begin
      m_en = wd[6];
      m_mode = wd[4];
      if (wd[3:0] <= 4'h8) m_code = int'(wd[3:0]);
    end
    m_arm = we && !m_arm && wd[7];
  endtask

  task automatic step(input bit we, input bit [7:0] wd, input bit tk);
    @(negedge clk);
    compare();
    wr_en_i = we; wr_data_i = wd; tick_i = tk;
    model(we, wd, tk);
  endtask

  task automatic prog(input bit [7:0] v);
    step(1'b1, 8'h80, 1'b0);
    step(1'b1, v, 1'b0);
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  // count ticks until irq rises (interrupt mode)
  task automatic ticks_to_irq(output int n);
    n = 0;
    while (n < 600) begin
      step(1'b0, 8'h00, 1'b1);
      n++;
      after_edge();
      if (irq_o) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1 reset state
    chk("R1 rd", rd_data_o, 8'h00);
    chk("R1 rst", rst_req_o, 0);
    chk("R1 irq", irq_o, 0);
    // R11 vector
    tag = "R11";
    chk("R11 vector", irq_vec_o, 8'h5B);

    // R3 stray write without unlock
    tag = "R3";
    step(1'b1, 8'h40, 1'b0);
    after_edge();
    chk("R3 stray write", rd_data_o, 8'h00);
    // R2 unlock opens a one-cycle window
    tag = "R2";
    step(1'b1, 8'h80, 1'b0);
    after_edge();
    chk("R2 armed", rd_data_o[7], 1);
    step(1'b0, 8'h00, 1'b0);
    after_edge();
    chk("R2 window closed", rd_data_o[7], 0);
    tag = "R3";
    step(1'b1, 8'h40, 1'b0);
    after_edge();
    chk("R3 late write", rd_data_o, 8'h00);

    // R5 reset mode, code 1 = 4 ticks
    tag = "R5";
    prog(8'h41);
    repeat (3) step(1'b0, 8'h00, 1'b1);
    after_edge();
    chk("R5 early", rst_req_o, 0);
    step(1'b0, 8'h00, 1'b1);
    after_edge();
    chk("R5 pulse", rst_req_o, 1);
    chk("R5 status", rd_data_o[5], 1);
    chk("R6 no irq in reset mode", irq_o, 0);
    step(1'b0, 8'h00, 1'b0);
    after_edge();
    chk("R5 single pulse", rst_req_o, 0);

    // R7 stray write leaves status, accepted write clears it
    tag = "R7";
    step(1'b1, 8'h00, 1'b0);
    after_edge();
    chk("R7 status kept", rd_data_o[5], 1);
    prog(8'h41);
    after_edge();
    chk("R7 status cleared", rd_data_o[5], 0);

    // R4 and R6: every period in interrupt mode
    for (int c = 0; c < 8; c++) begin
      tag = "R4";
      prog(8'h50 | 8'(c));
      ticks_to_irq(n);
      chk("R4 period ticks", n, 2 << c);
      chk("R6 irq no rst", rst_req_o, 0);
      tag = "R6";
      step(1'b0, 8'h00, 1'b0);
    end

    // R10 restart
    tag = "R10";
    prog(8'h52);
    repeat (6) step(1'b0, 8'h00, 1'b1);
    prog(8'h52);
    ticks_to_irq(n);
    chk("R10 full period after restart", n, 8);
    // write in same cycle as the expiring tick: restart wins
    prog(8'h51);
    repeat (3) step(1'b0, 8'h00, 1'b1);
    step(1'b1, 8'h80, 1'b0);
    step(1'b1, 8'h51, 1'b1);
    after_edge();
    chk("R10 write beats expiry", irq_o, 0);

    // R9 reserved code
    tag = "R9";
    prog(8'h43);
    prog(8'h5C);
    after_edge();
    chk("R9 code kept", rd_data_o, 8'h53);

    // R12 disabled
    tag = "R12";
    prog(8'h10);
    repeat (300) step(1'b0, 8'h00, 1'b1);
    after_edge();
    chk("R12 no expiry", irq_o, 0);
    chk("R12 no reset", rst_req_o, 0);

    // R8 immediate reset
    tag = "R8";
    step(1'b1, 8'h80, 1'b0);
    step(1'b1, 8'h48, 1'b0);
    after_edge();
    chk("R8 immediate pulse", rst_req_o, 1);
    repeat (20) step(1'b0, 8'h00, 1'b1);
    after_edge();
    chk("R8 held code stops count", rst_req_o, 0);
    step(1'b0, 8'h00, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule